// File: doc/BRIEF.md
# Serial Overhead Byte Fetch Port

This block supplies transport-overhead bytes to a frame generator from an external source over a narrow bit-serial port. The generator offers overhead byte positions one at a time. A per-position source-select table decides which positions come from the external source. For each such position, the block sends the 10-bit position address serially, leaves one idle cycle, and then reads an 8-bit byte serially from the external source. The fetched byte is returned to the generator with its address in a one-cycle strobe, ready for insertion into the outgoing frame.

The port serves either one STM-4 frame or four byte-interleaved STM-1 frames, depending on a line mode input. The two parity overhead bytes are handled differently from the others. At those positions the fetched byte does not replace the value. It is XORed onto the parity value that the neighbouring logic has calculated, so the external source can inject parity errors on purpose. Frame timing and parity calculation stay outside the block.

Top module: `ovh_byte_fetch`

## Requirements
- R1: The position address is `{row-1[3:0], column-1[3:0], interleave-1[1:0]}`, with the row at bits 9..6, the column at bits 5..2 and the interleave at bits 1..0. It is shifted out on `addr_sd_o` most significant bit first. `ale_o` is high for exactly the 10 cycles that follow request acceptance.
- R2: After the last address cycle there is exactly one cycle in which neither `ale_o` nor `dle_o` is high. The two enables are never high together.
- R3: `dle_o` is then high for exactly 8 cycles. `data_sd_i` is sampled at the rising clock edge that ends each of these cycles, and the first bit sampled is the most significant bit of the byte.
- R4: In the cycle after the 8th data bit is sampled, `vld_o` is high for exactly one cycle, with `byte_o` holding the result and `byte_addr_o` holding the requested address.
- R5: A table write with `cfg_sel_i`=1 marks a position as externally sourced, and a write with 0 clears the mark. A request for a position that is not marked starts no port transaction and produces no `vld_o`.
- R6: When `is_par_i` is high at request acceptance, `byte_o` is the fetched byte XOR `calc_par_i` as captured at acceptance. Otherwise `byte_o` is the fetched byte unchanged.
- R7: A request or table write whose row field or column field exceeds 8 is ignored. No transaction starts.
- R8: With `stm4_mode_i`=1, requests whose interleave field is not 0 are ignored. With `stm4_mode_i`=0, interleave values 0 to 3 are all served.
- R9: `busy_o` is high from the cycle after acceptance until the last data cycle. Requests that arrive while `busy_o` is high are dropped.
- R10: The asynchronous active-low reset `rst_ni` immediately forces the sequencer idle, drives `ale_o`, `dle_o`, `addr_sd_o`, `vld_o` and `busy_o` low, and clears every table mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block and port clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stm4_mode_i | input | 1 | 1: one STM-4 frame; 0: four interleaved STM-1 frames |
| cfg_we_i | input | 1 | Source-select table write strobe |
| cfg_addr_i | input | 10 | Position written, same layout as the request address |
| cfg_sel_i | input | 1 | Select bit (entry MSB): 1 = fetch externally |
| req_i | input | 1 | Generator offers a byte position |
| req_addr_i | input | 10 | Offered position address |
| is_par_i | input | 1 | Offered position is a parity byte |
| calc_par_i | input | 8 | Internally calculated parity for that position |
| busy_o | output | 1 | Port transaction in progress |
| port_clk_o | output | 1 | Port clock; outputs change on its rising edge |
| ale_o | output | 1 | Address latch enable |
| addr_sd_o | output | 1 | Serial address out |
| dle_o | output | 1 | Data latch enable |
| data_sd_i | input | 1 | Serial data in |
| vld_o | output | 1 | Fetched byte strobe |
| byte_o | output | 8 | Fetched or parity-masked byte |
| byte_addr_o | output | 10 | Address of the byte in `byte_o` |

## Verification
Assertions check the shape of every transaction on every cycle. They cover the 10-cycle address enable window, the single gap cycle, the 8-cycle data window, the mutual exclusion of the two enables, the single-cycle valid strobe, quiet outputs while idle, and the rule that an invalid position never raises `busy_o`. Other behaviours only show up in the bench scenarios, because checking them needs expected values. These are the bit order and field layout of the serialized address, the assembled byte value, the parity XOR, the table lookup per position, the dropping of overlapping requests, and the clearing of table marks by reset.

// File: rtl/ovh_fetch_pkg.sv
package ovh_fetch_pkg;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 8;
  localparam int ROW_LSB = 6;
  localparam int COL_LSB = 2;
  localparam int FLD_W = 4;
  localparam int IL_W = 2;
  localparam int N_ROW = 9;
  localparam int N_COL = 9;
  localparam int N_IL = 4;
  localparam int N_POS = N_ROW * N_COL * N_IL;
  localparam int CNT_W = $clog2(ADDR_W);

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_GAP, ST_DATA} seq_st_e;

  function automatic logic fld_ok(logic [ADDR_W-1:0] a);
    return (int'(a[ROW_LSB +: FLD_W]) < N_ROW) && (int'(a[COL_LSB +: FLD_W]) < N_COL);
  endfunction

  function automatic logic req_ok(logic [ADDR_W-1:0] a, logic stm4);
    return fld_ok(a) && !(stm4 && (a[IL_W-1:0] != '0));
  endfunction
endpackage

// File: rtl/ovh_src_table.sv
module ovh_src_table
  import ovh_fetch_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic              wsel_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic              rsel_o
);
  localparam int IDX_W = $clog2(N_POS);

  logic [N_POS-1:0] sel_q;
  logic [IDX_W-1:0] widx, ridx;

  function automatic logic [IDX_W-1:0] pos_idx(logic [ADDR_W-1:0] a);
    int v;
    v = int'(a[ROW_LSB +: FLD_W]) * N_COL * N_IL
      + int'(a[COL_LSB +: FLD_W]) * N_IL
      + int'(a[IL_W-1:0]);
    return IDX_W'(v);
  endfunction

  assign widx = pos_idx(waddr_i);
  assign ridx = pos_idx(raddr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else if (we_i && fld_ok(waddr_i)) sel_q[widx] <= wsel_i;
  end

  assign rsel_o = fld_ok(raddr_i) ? sel_q[ridx] : 1'b0;
endmodule

// File: rtl/ovh_req_seq.sv
module ovh_req_seq
  import ovh_fetch_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              busy_o,
  output logic              ale_o,
  output logic              asd_o,
  output logic              dle_o,
  input  logic              dsd_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic [ADDR_W-1:0] done_addr_o
);
  seq_st_e           st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] ash_q, addr_q;
  logic [DATA_W-1:0] dsh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      ash_q  <= '0;
      addr_q <= '0;
      dsh_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_ADDR;
          ash_q  <= addr_i;
          addr_q <= addr_i;
          cnt_q  <= '0;
        end
        ST_ADDR: begin
          ash_q <= ash_q << 1;
          if (cnt_q == CNT_W'(ADDR_W - 1)) begin
            st_q  <= ST_GAP;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_GAP: st_q <= ST_DATA;
        ST_DATA: begin
          dsh_q <= {dsh_q[DATA_W-2:0], dsd_i};
          if (cnt_q == CNT_W'(DATA_W - 1)) st_q <= ST_IDLE;
          else cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign ale_o       = (st_q == ST_ADDR);
  assign asd_o       = ale_o & ash_q[ADDR_W-1];
  assign dle_o       = (st_q == ST_DATA);
  assign done_o      = dle_o && (cnt_q == CNT_W'(DATA_W - 1));
  assign data_o      = {dsh_q[DATA_W-2:0], dsd_i};
  assign done_addr_o = addr_q;

  p_ale_run_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ale_o) |-> ##9 ale_o);
  p_ale_end_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ale_o) |-> ##10 !ale_o);
  p_gap_one_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ale_o) |-> (!dle_o ##1 dle_o));
  p_le_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ale_o && dle_o));
  p_dle_run_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dle_o) |-> ##7 dle_o);
  p_dle_end_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dle_o) |-> ##8 !dle_o);
endmodule

// File: rtl/ovh_par_mask.sv
module ovh_par_mask
  import ovh_fetch_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              par_i,
  input  logic [DATA_W-1:0] calc_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] raw_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] byte_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [DATA_W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      vld_o  <= 1'b0;
      byte_o <= '0;
      addr_o <= '0;
    end else begin
      if (arm_i) mask_q <= par_i ? calc_i : '0;
      vld_o <= done_i;
      if (done_i) begin
        byte_o <= raw_i ^ mask_q;
        addr_o <= addr_i;
      end
    end
  end

  p_vld_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |=> !vld_o);
endmodule

// File: rtl/ovh_byte_fetch.sv
module ovh_byte_fetch
  import ovh_fetch_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stm4_mode_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic              cfg_sel_i,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              is_par_i,
  input  logic [DATA_W-1:0] calc_par_i,
  output logic              busy_o,
  output logic              port_clk_o,
  output logic              ale_o,
  output logic              addr_sd_o,
  output logic              dle_o,
  input  logic              data_sd_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] byte_o,
  output logic [ADDR_W-1:0] byte_addr_o
);
  logic              pos_sel, start, done;
  logic [DATA_W-1:0] raw;
  logic [ADDR_W-1:0] done_addr;

  assign port_clk_o = clk_i;

  ovh_src_table i_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .waddr_i (cfg_addr_i),
    .wsel_i  (cfg_sel_i),
    .raddr_i (req_addr_i),
    .rsel_o  (pos_sel)
  );

  assign start = req_i && !busy_o && pos_sel && req_ok(req_addr_i, stm4_mode_i);

  ovh_req_seq i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .addr_i      (req_addr_i),
    .busy_o      (busy_o),
    .ale_o       (ale_o),
    .asd_o       (addr_sd_o),
    .dle_o       (dle_o),
    .dsd_i       (data_sd_i),
    .done_o      (done),
    .data_o      (raw),
    .done_addr_o (done_addr)
  );

  ovh_par_mask i_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (start),
    .par_i  (is_par_i),
    .calc_i (calc_par_i),
    .done_i (done),
    .raw_i  (raw),
    .addr_i (done_addr),
    .vld_o  (vld_o),
    .byte_o (byte_o),
    .addr_o (byte_addr_o)
  );

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!ale_o && !dle_o && !addr_sd_o));
  p_bad_pos_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && !fld_ok(req_addr_i)) |=> !busy_o);
  p_stm4_il_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && stm4_mode_i && (req_addr_i[IL_W-1:0] != '0)) |=> !busy_o);
  p_vld_after_data_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> $past(dle_o));
endmodule

// File: tb/test_ovh_byte_fetch.sv
module test_ovh_byte_fetch;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // {addr[9:0], data[7:0], par, calc[7:0], expect_start}
  localparam logic [27:0] VECS [NV] = '{
    {4'd0, 4'd0, 2'd0, 8'hA5, 1'b0, 8'h00, 1'b1},
    {4'd8, 4'd8, 2'd3, 8'h3C, 1'b0, 8'h00, 1'b1},
    {4'd2, 4'd5, 2'd1, 8'h81, 1'b0, 8'h00, 1'b1},
    {4'd3, 4'd0, 2'd2, 8'h0F, 1'b1, 8'hF0, 1'b1},
    {4'd7, 4'd3, 2'd0, 8'h55, 1'b1, 8'h55, 1'b1},
    {4'd1, 4'd1, 2'd1, 8'h77, 1'b0, 8'h00, 1'b0},
    {4'd9, 4'd0, 2'd0, 8'h12, 1'b0, 8'h00, 1'b0},
    {4'd0, 4'd9, 2'd0, 8'h12, 1'b0, 8'h00, 1'b0}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic stm4 = 1'b0, cfg_we = 1'b0, cfg_sel = 1'b0, req = 1'b0, is_par = 1'b0, dsd = 1'b0;
  logic [9:0] cfg_addr = '0, req_addr = '0;
  logic [7:0] calc = '0;
  logic busy, pclk, ale, asd, dle, vld;
  logic [7:0] byte_v;
  logic [9:0] byte_addr;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ovh_byte_fetch i_ovh_byte_fetch (
    .clk_i(clk), .rst_ni(rst_ni), .stm4_mode_i(stm4),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_sel_i(cfg_sel),
    .req_i(req), .req_addr_i(req_addr), .is_par_i(is_par), .calc_par_i(calc),
    .busy_o(busy), .port_clk_o(pclk), .ale_o(ale), .addr_sd_o(asd),
    .dle_o(dle), .data_sd_i(dsd), .vld_o(vld), .byte_o(byte_v), .byte_addr_o(byte_addr)
  );

  task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req_tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [9:0] a, input logic s);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_sel = s;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_req(input logic [9:0] a, input logic [7:0] d, input logic par,
                        input logic [7:0] cp, input bit exp_start, input bit overlap,
                        input string tag);
    int ale_n = 0, gap_n = 0, dle_n = 0, vld_n = 0;
    logic [9:0] got_a = '0, got_ba = '0;
    logic [7:0] got_b = '0, exp_b;
    @(negedge clk);
    req = 1'b1; req_addr = a; is_par = par; calc = cp;
    @(negedge clk);
    req = 1'b0; is_par = 1'b0; calc = 8'h00;
    for (int i = 0; i < 24; i++) begin
      if (ale) begin got_a = {got_a[8:0], asd}; ale_n++; end
      else if (dle) begin dsd = d[7-dle_n]; dle_n++; end
      else if (ale_n > 0 && dle_n == 0) gap_n++;
      if (vld) begin vld_n++; got_b = byte_v; got_ba = byte_addr; end
      if (overlap && i == 4) begin req = 1'b1; req_addr = 10'h004; end
      if (overlap && i == 5) req = 1'b0;
      @(negedge clk);
    end
    exp_b = par ? (d ^ cp) : d;
    if (exp_start) begin
      chk(ale_n == 10, {tag, " R1 ale cycles"}, ale_n, 10);
      chk(got_a == a, {tag, " R1 address bits"}, got_a, a);
      chk(gap_n == 1, {tag, " R2 gap cycles"}, gap_n, 1);
      chk(dle_n == 8, {tag, " R3 dle cycles"}, dle_n, 8);
      chk(vld_n == 1, {tag, " R4 vld pulses"}, vld_n, 1);
      chk(got_b == exp_b, {tag, par ? " R6 masked byte" : " R3 byte"}, got_b, exp_b);
      chk(got_ba == a, {tag, " R4 byte addr"}, got_ba, a);
    end else begin
      chk(ale_n == 0, {tag, " R5/R7 no ale"}, ale_n, 0);
      chk(vld_n == 0, {tag, " R5/R7 no vld"}, vld_n, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    chk(!ale && !dle && !asd && !busy && !vld, "R10 reset outputs", {ale, dle, asd, busy, vld}, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    cfg({4'd0, 4'd0, 2'd0}, 1'b1);
    cfg({4'd8, 4'd8, 2'd3}, 1'b1);
    cfg({4'd2, 4'd5, 2'd1}, 1'b1);
    cfg({4'd3, 4'd0, 2'd2}, 1'b1);
    cfg({4'd7, 4'd3, 2'd0}, 1'b1);
    cfg({4'd9, 4'd0, 2'd0}, 1'b1); // R7 write ignored
    cfg({4'd0, 4'd9, 2'd0}, 1'b1);
    cfg({4'd0, 4'd0, 2'd1}, 1'b1);
    cfg({4'd1, 4'd1, 2'd1}, 1'b1);
    cfg({4'd1, 4'd1, 2'd1}, 1'b0); // R5 mark cleared

    for (int v = 0; v < NV; v++)
      do_req(VECS[v][27:18], VECS[v][17:10], VECS[v][9], VECS[v][8:1], VECS[v][0], 1'b0,
             $sformatf("vec%0d", v));

    // R8: interleave handling per line mode
    stm4 = 1'b1;
    do_req({4'd0, 4'd0, 2'd1}, 8'h99, 1'b0, 8'h00, 1'b0, 1'b0, "R8 stm4 il1");
    do_req({4'd0, 4'd0, 2'd0}, 8'h6E, 1'b0, 8'h00, 1'b1, 1'b0, "R8 stm4 il0");
    stm4 = 1'b0;
    do_req({4'd0, 4'd0, 2'd1}, 8'hC3, 1'b0, 8'h00, 1'b1, 1'b0, "R8 stm1 il1");

    // R9: overlapping request dropped
    do_req({4'd2, 4'd5, 2'd1}, 8'h5A, 1'b0, 8'h00, 1'b1, 1'b1, "R9 overlap");
    repeat (3) @(negedge clk);
    chk(!busy && !ale, "R9 no second transaction", {busy, ale}, 0);

    // R10: reset mid-transaction
    @(negedge clk);
    req = 1'b1; req_addr = '0;
    @(negedge clk);
    req = 1'b0;
    repeat (4) @(negedge clk);
    chk(busy && ale, "R9 busy during address", {busy, ale}, 3);
    rst_ni = 1'b0;
    #1;
    chk(!ale && !dle && !asd && !busy && !vld, "R10 async reset", {ale, dle, asd, busy, vld}, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    do_req({4'd0, 4'd0, 2'd0}, 8'hA5, 1'b0, 8'h00, 1'b0, 1'b0, "R10 table cleared");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule